// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked system read and write an external asynchronous static RAM that stores one bit per address, with separate data-in and data-out pins, an active-low select and an active-low write strobe. The memory has no clock. The controller therefore makes every timing window from a whole number of its own clock cycles. The three counts are parameters, so one design serves any speed grade. Each count is the nanosecond figure divided by the clock period, rounded up, and is never less than one.

A user presents one request at a time: a valid flag, a write flag, an address and a write bit. The request is taken on a clock edge while the ready output is high. A read keeps the select low with the strobe high for the access window, plus one extra cycle, and then captures the data-out pin. A write first drives the address and data with the select low. The strobe falls one cycle later and stays low for a counted pulse. The strobe and select then rise together, and the address and data stay fixed through a counted recovery gap. Every memory-side pin comes straight from a register. Completion is signalled by a one-cycle done pulse. For a read, the captured bit is on the read-data output in the same cycle.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held, and on the cycle after its release, select and strobe are high (deasserted), done is low and ready is high.
- R2: Ready is high only when no request is in progress. A valid flag raised while ready is low is ignored: the memory address does not change and no memory bit is written for it.
- R3: A read accepted on edge E0 holds select low and strobe high from E0 on. It captures the data-out pin on edge E0+ACC+1, where ACC is the access count. Done and the new read bit appear on that same edge.
- R4: For a write, the address and data-in are loaded on the accept edge and select falls on that edge. The strobe falls one cycle later. Address and data stay unchanged for as long as select is low.
- R5: The strobe stays low for exactly PULSE cycles, where PULSE is the pulse count.
- R6: Strobe and select rise on the same edge. Address and data-in then stay fixed for at least REC+1 cycles, where REC is the recovery count. Done for a write is set on edge E0+1+PULSE+REC.
- R7: The strobe is never low while select is high.
- R8: Done is high for exactly one cycle for each accepted request, and never at any other time.
- R9: The read-data output changes only on a read capture. It keeps its value across writes, and the data-out pin is never sampled while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 1 | Bit to write |
| req_ready | output | 1 | Controller idle; a request is taken on the next edge |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 1 | Last bit read |
| mem_addr | output | AW | Address pins of the memory |
| mem_cs_n | output | 1 | Active-low memory select |
| mem_we_n | output | 1 | Active-low memory write strobe |
| mem_d | output | 1 | Memory data-in pin |
| mem_q | input | 1 | Memory data-out pin |

## Verification
The bench uses a cycle-counting memory model that returns inverted data until the address has been stable for the full access window. A controller that samples one cycle early therefore reads the wrong bit. The model measures the strobe width, checks that select was already low when the strobe fell, and flags any address or data movement while the strobe is low or during recovery. A design with a short pulse, a missing setup cycle or a short recovery gap therefore raises failures. Requests held high while the controller is busy are followed by reads of the addresses they named. A design that accepted such a request would leave an unexpected bit in memory and an unexpected done pulse. Reads and writes at address 0 and at the highest address, and data-out levels that change between reads, catch truncated addresses and stale captures.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_RD_WAIT   = 3'd1,
    ST_RD_SAMPLE = 3'd2,
    ST_WR_SETUP  = 3'd3,
    ST_WR_PULSE  = 3'd4,
    ST_WR_RECOV  = 3'd5
  } ctl_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int TACC_CYC = 1,
  parameter int TWP_CYC  = 1,
  parameter int TREC_CYC = 1,
  parameter int CW       = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          cnt_zero,
  output ctl_state_e    state,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output logic          accept,
  output logic          strobe_fall,
  output logic          release_pins,
  output logic          sample,
  output logic          finish
);

  localparam logic [CW-1:0] ACC_LOAD = CW'(TACC_CYC - 1);
  localparam logic [CW-1:0] WP_LOAD  = CW'(TWP_CYC - 1);
  localparam logic [CW-1:0] REC_LOAD = CW'(TREC_CYC - 1);

  ctl_state_e state_q;
  ctl_state_e state_d;

  always_comb begin
    state_d      = state_q;
    cnt_load     = 1'b0;
    cnt_val      = '0;
    accept       = 1'b0;
    strobe_fall  = 1'b0;
    release_pins = 1'b0;
    sample       = 1'b0;
    finish       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_write) begin
            state_d = ST_WR_SETUP;
          end else begin
            cnt_load = 1'b1;
            cnt_val  = ACC_LOAD;
            state_d  = ST_RD_WAIT;
          end
        end
      end
      ST_RD_WAIT: begin
        if (cnt_zero) state_d = ST_RD_SAMPLE;
      end
      ST_RD_SAMPLE: begin
        sample       = 1'b1;
        finish       = 1'b1;
        release_pins = 1'b1;
        state_d      = ST_IDLE;
      end
      ST_WR_SETUP: begin
        strobe_fall = 1'b1;
        cnt_load    = 1'b1;
        cnt_val     = WP_LOAD;
        state_d     = ST_WR_PULSE;
      end
      ST_WR_PULSE: begin
        if (cnt_zero) begin
          release_pins = 1'b1;
          cnt_load     = 1'b1;
          cnt_val      = REC_LOAD;
          state_d      = ST_WR_RECOV;
        end
      end
      ST_WR_RECOV: begin
        if (cnt_zero) begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

  // R3
  rd_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_SAMPLE) |-> $past(state_q == ST_RD_WAIT))
    else $error("read capture not preceded by access wait");

endmodule

// File: rtl/asram_pins.sv
module asram_pins #(
  parameter int AW      = 20,
  parameter int TWP_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wdata,
  input  logic          strobe_fall,
  input  logic          release_pins,
  input  logic          sample,
  input  logic          finish,
  input  logic          mem_q,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_d,
  output logic          rdata,
  output logic          done
);

  localparam int WCW = $clog2(TWP_CYC + 2);

  logic [AW-1:0] addr_q;
  logic          cs_n_q, we_n_q, d_q, rdata_q, done_q;
  logic          d_en, cs_en, we_en;

  always_comb begin
    d_en  = accept && req_write;
    cs_en = accept || release_pins;
    we_en = strobe_fall || release_pins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= 1'b0;
    end else if (d_en) begin
      d_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= 1'b1;
    end else if (cs_en) begin
      cs_n_q <= !accept;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_n_q <= 1'b1;
    end else if (we_en) begin
      we_n_q <= !strobe_fall;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= 1'b0;
    end else if (sample) begin
      rdata_q <= mem_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
    end
  end

  assign mem_addr = addr_q;
  assign mem_cs_n = cs_n_q;
  assign mem_we_n = we_n_q;
  assign mem_d    = d_q;
  assign rdata    = rdata_q;
  assign done     = done_q;

  logic [WCW-1:0] we_low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
    end else if (!we_n_q) begin
      we_low_cnt <= we_low_cnt + 1'b1;
    end else begin
      we_low_cnt <= '0;
    end
  end

  // R7
  strobe_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n)
    else $error("write strobe low while deselected");

  // R4
  strobe_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_cs_n))
    else $error("strobe fell without select already low");

  // R4
  pins_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_d)))
    else $error("address or data moved during select");

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == WCW'(TWP_CYC)))
    else $error("write strobe width wrong");

  // R6
  joint_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $rose(mem_cs_n))
    else $error("strobe and select did not rise together");

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done wider than one cycle");

  // R9
  rdata_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> $past(!mem_cs_n && mem_we_n))
    else $error("read bit changed outside a read");

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW       = 20,
  parameter int TACC_CYC = 1,
  parameter int TWP_CYC  = 1,
  parameter int TREC_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wdata,
  output logic          req_ready,
  output logic          rsp_done,
  output logic          rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_d,
  input  logic          mem_q
);

  localparam int MAXC = max3(TACC_CYC, TWP_CYC, TREC_CYC);
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

  ctl_state_e    state;
  logic          cnt_load, cnt_zero;
  logic [CW-1:0] cnt_val;
  logic          accept, strobe_fall, release_pins, sample, finish;

  asram_fsm #(
    .TACC_CYC (TACC_CYC),
    .TWP_CYC  (TWP_CYC),
    .TREC_CYC (TREC_CYC),
    .CW       (CW)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .cnt_zero     (cnt_zero),
    .state        (state),
    .cnt_load     (cnt_load),
    .cnt_val      (cnt_val),
    .accept       (accept),
    .strobe_fall  (strobe_fall),
    .release_pins (release_pins),
    .sample       (sample),
    .finish       (finish)
  );

  asram_phase_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  asram_pins #(.AW(AW), .TWP_CYC(TWP_CYC)) u_pins (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .strobe_fall  (strobe_fall),
    .release_pins (release_pins),
    .sample       (sample),
    .finish       (finish),
    .mem_q        (mem_q),
    .mem_addr     (mem_addr),
    .mem_cs_n     (mem_cs_n),
    .mem_we_n     (mem_we_n),
    .mem_d        (mem_d),
    .rdata        (rsp_rdata),
    .done         (rsp_done)
  );

  assign req_ready = (state == ST_IDLE);

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(mem_addr))
    else $error("address reloaded while busy");

  // R6
  done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (mem_cs_n && mem_we_n))
    else $error("done raised with memory still selected");

endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

  localparam int AW   = 20;
  localparam int TACC = 3;
  localparam int TWP  = 2;
  localparam int TREC = 2;
  localparam int RD_LAT = TACC + 1;
  localparam int WR_LAT = 1 + TWP + TREC;

  logic          clk, rst_n;
  logic          req_valid, req_write, req_wdata;
  logic [AW-1:0] req_addr;
  logic          req_ready, rsp_done, rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n, mem_we_n, mem_d;
  logic          q_reg;

  asram_ctrl #(.AW(AW), .TACC_CYC(TACC), .TWP_CYC(TWP), .TREC_CYC(TREC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_d(mem_d), .mem_q(q_reg)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // ---------------- memory model ----------------
  bit            mem_arr [int unsigned];
  int            acc_cnt, we_low, rec_cnt;
  bit            in_rec;
  logic [AW-1:0] prev_addr;
  logic          prev_cs_n, prev_we_n, prev_d;

  function automatic bit mem_rd(input logic [AW-1:0] a);
    return mem_arr.exists(int'(a)) ? mem_arr[int'(a)] : 1'b0;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      acc_cnt = 0; we_low = 0; rec_cnt = 0; in_rec = 0;
      prev_addr = mem_addr; prev_cs_n = 1'b1; prev_we_n = 1'b1; prev_d = 1'b0;
      q_reg = 1'bz;
    end else begin
      if (mem_cs_n || !mem_we_n) acc_cnt = 0;
      else if (prev_cs_n || mem_addr != prev_addr) acc_cnt = 1;
      else acc_cnt++;
      if (!mem_we_n && mem_cs_n) chk(1'b0, "R7 strobe low while deselected", 0, 1);
      if (!mem_cs_n && !mem_we_n) begin
        if (prev_we_n)
          chk(!prev_cs_n && mem_addr == prev_addr && mem_d == prev_d,
              "R4 select and pins set a cycle before strobe", int'(prev_cs_n), 0);
        else if (mem_addr != prev_addr || mem_d != prev_d)
          chk(1'b0, "R4 pins moved under strobe", 1, 0);
        we_low++;
      end
      if (in_rec) begin
        if (mem_addr != prev_addr || mem_d != prev_d) begin
          chk(rec_cnt > TREC, "R6 recovery hold cycles", rec_cnt, TREC + 1);
          in_rec = 0;
        end else begin
          rec_cnt++;
          if (rec_cnt > TREC + 1) in_rec = 0;
        end
      end
      if (!prev_we_n && mem_we_n) begin
        chk(we_low == TWP, "R5 strobe width", we_low, TWP);
        chk(mem_cs_n, "R6 select rises with strobe", int'(mem_cs_n), 1);
        mem_arr[int'(prev_addr)] = prev_d;
        we_low = 0; rec_cnt = 1; in_rec = 1;
      end
      prev_addr = mem_addr; prev_cs_n = mem_cs_n; prev_we_n = mem_we_n; prev_d = mem_d;
      if (!mem_cs_n && mem_we_n)
        q_reg = (acc_cnt >= TACC + 1) ? mem_rd(mem_addr) : ~mem_rd(mem_addr);
      else
        q_reg = 1'bz;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit wr; bit exp; int acc; } item_t;
  item_t sbq[$];
  bit    shadow [int unsigned];
  bit    last_rd = 1'b0;

  task automatic do_op(input bit wr, input logic [AW-1:0] a, input bit dat);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dat;
    it.wr  = wr;
    it.acc = cyc + 1;
    if (wr) begin
      shadow[int'(a)] = dat;
      it.exp = dat;
    end else begin
      it.exp = shadow.exists(int'(a)) ? shadow[int'(a)] : 1'b0;
    end
    sbq.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_done) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R8 done without a request", 1, 0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        if (it.wr) begin
          chk(cyc - it.acc == WR_LAT, "R6 write done latency", cyc - it.acc, WR_LAT);
          chk(rsp_rdata == last_rd, "R9 read bit kept across write", int'(rsp_rdata), int'(last_rd));
        end else begin
          chk(cyc - it.acc == RD_LAT, "R3 read done latency", cyc - it.acc, RD_LAT);
          chk(rsp_rdata === it.exp, "R3 read data", int'(rsp_rdata), int'(it.exp));
          last_rd = it.exp;
        end
      end
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 60000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 60000", cyc);
      report();
    end
  end

  // ---------------- stimulus ----------------
  logic [AW-1:0] lfsr;
  logic [AW-1:0] addrs [0:31];

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_we_n && !rsp_done && req_ready, "R1 reset state",
        {mem_cs_n, mem_we_n, rsp_done, req_ready}, 4'b1101);
    @(posedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(mem_cs_n && mem_we_n && !rsp_done && req_ready, "R1 after release",
        {mem_cs_n, mem_we_n, rsp_done, req_ready}, 4'b1101);

    do_op(1'b0, 20'h00000, 1'b0);
    do_op(1'b1, 20'h00000, 1'b1);
    do_op(1'b0, 20'h00000, 1'b0);
    do_op(1'b1, 20'hFFFFF, 1'b1);
    do_op(1'b0, 20'hFFFFF, 1'b0);
    do_op(1'b1, 20'hFFFFF, 1'b0);
    do_op(1'b0, 20'hFFFFF, 1'b0);
    do_op(1'b0, 20'h00000, 1'b0);

    lfsr = 20'hACE1;
    for (int i = 0; i < 32; i++) begin
      lfsr = {lfsr[18:0], lfsr[19] ^ lfsr[16]};
      addrs[i] = lfsr;
      do_op(1'b1, lfsr, lfsr[3] ^ lfsr[0]);
    end
    for (int i = 31; i >= 0; i--) do_op(1'b0, addrs[i], 1'b0);

    // R2: request held while busy must be ignored
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    begin
      item_t it;
      req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h12345; req_wdata = 1'b1;
      shadow[int'(20'h12345)] = 1'b1;
      it.wr = 1'b1; it.exp = 1'b1; it.acc = cyc + 1;
      sbq.push_back(it);
    end
    @(negedge clk);
    chk(!req_ready, "R2 ready low while busy", int'(req_ready), 0);
    req_addr = 20'h54321; req_wdata = 1'b1;
    @(negedge clk);
    chk(mem_addr == 20'h12345, "R2 address unchanged by busy request", int'(mem_addr), int'(20'h12345));
    @(negedge clk);
    req_valid = 1'b0;
    do_op(1'b0, 20'h54321, 1'b0);
    do_op(1'b0, 20'h12345, 1'b0);

    repeat (WR_LAT + RD_LAT + 4) @(negedge clk);
    chk(sbq.size() == 0, "R8 every request completed once", sbq.size(), 0);
    report();
  end

endmodule